// File: doc/BRIEF.md
# Privilege-Raising Stack Switch Sequencer

This unit performs the memory traffic that follows an approved transfer into more privileged code. Once the protection checks have decided that a gate entry raises privilege, the unit takes over. It fetches the stack segment and stack pointer that belong to the target level from a per-task state area, and from then on it works on that new stack. On the new stack it saves the caller's stack segment and stack pointer. It then saves either a block of caller parameters copied from the old stack (call gates) or the flags word (interrupt gates). Last it saves the return code segment and instruction pointer. When the sequence ends it reports the new stack, the entry point taken from the gate, and the new current privilege level.

All memory traffic goes through one word-wide request/acknowledge port, one access at a time. A stack address is the segment selector in the upper half and the 16-bit offset in the lower half. The state-area address is a flat byte address formed from a base value. The surrounding core drives all inputs on the cycle it raises `start`. The unit captures them on that cycle, so the core may change them afterwards.

Top module: `priv_stack_switch`

## Requirements
- R1: After reset, `busy`, `done` and `mem_req` are low.
- R2: The first two accesses are reads from the task state area: the new SP from byte address `tsa_base + 2 + 4*tgt_dpl`, then the new SS from `tsa_base + 4 + 4*tgt_dpl`.
- R3: The caller's SS is pushed first and the caller's SP second. Every push lowers the new SP by 2 (modulo 2^16) before the write. The write goes to address `{new_ss, new_sp}`, with the selector in bits 31:16 and the offset in bits 15:0.
- R4: For a call gate (`gate_kind`=0), `gate_wcnt` words (0 to 31) are copied from the old stack after the saved SS:SP. The deepest word, at `{cur_ss, cur_sp + 2*(gate_wcnt-1)}`, is read and pushed first and the word at `cur_sp` last. A count of zero copies nothing.
- R5: For an interrupt gate (`gate_kind`=1), exactly one word, `cur_flags`, is pushed in place of the parameters, and `gate_wcnt` has no effect.
- R6: The return CS (`cur_cs`) is pushed, then the return IP (`cur_ip`); these are the last two accesses.
- R7: `done` is a one-cycle pulse after the last push. While it is high, `out_ss`/`out_sp` hold the final new stack, `out_cs`/`out_ip` hold `gate_sel`/`gate_off`, and `out_cpl` holds `tgt_dpl`.
- R8: `busy` is high from the cycle after an accepted `start` through the `done` cycle, and low on the following cycle.
- R9: A `start` raised while `busy` is high is ignored, even if the other inputs change at the same time.
- R10: No request is made while idle. A request holds its address, direction and data until `mem_ack` is seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a sequence (taken when idle) |
| gate_kind | input | 1 | 0 = call gate, 1 = interrupt gate |
| tgt_dpl | input | 2 | Target privilege level |
| gate_sel | input | 16 | Code selector from the gate |
| gate_off | input | 16 | Entry offset from the gate |
| gate_wcnt | input | 5 | Parameter word count from a call gate |
| cur_ss | input | 16 | Caller stack segment |
| cur_sp | input | 16 | Caller stack pointer |
| cur_cs | input | 16 | Return code segment |
| cur_ip | input | 16 | Return instruction pointer |
| cur_flags | input | 16 | Flags word for interrupt entry |
| tsa_base | input | 32 | Base address of the task state area |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | 32 | Byte address of the word |
| mem_wdata | output | 16 | Write data |
| mem_ack | input | 1 | Access completed |
| mem_rdata | input | 16 | Read data, valid with `mem_ack` |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle completion pulse |
| out_ss | output | 16 | Final stack segment |
| out_sp | output | 16 | Final stack pointer |
| out_cs | output | 16 | New code segment |
| out_ip | output | 16 | New instruction pointer |
| out_cpl | output | 2 | New current privilege level |

## Verification
The sequence is run for call gates with no parameters, a few parameters and the full 31, and for interrupt gates at several target levels. Comparing these shows whether the copy loop, its ordering and its exit at zero are right, and whether the flags push replaces the copy loop. One interrupt case starts from a new SP of 2, so the pushes wrap the 16-bit offset and expose any carry into the selector half of the address. In the longest case `start` is pulsed again with different inputs mid-sequence; this separates a design that captures its inputs once from one that re-samples them. Memory acknowledges arrive after varying wait states, so every access is checked in order against the reference, not at fixed cycle positions.

// File: rtl/pss_pkg.sv
package pss_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_RD_SP,
        ST_RD_SS,
        ST_PU_SS,
        ST_PU_SP,
        ST_PU_FL,
        ST_RD_PRM,
        ST_PU_PRM,
        ST_PU_CS,
        ST_PU_IP,
        ST_FIN
    } seq_st_e;

    typedef enum logic {
        GATE_CALL = 1'b0,
        GATE_INTR = 1'b1
    } gate_kind_e;

    function automatic logic st_is_push(seq_st_e s);
        return (s == ST_PU_SS) || (s == ST_PU_SP) || (s == ST_PU_FL) ||
               (s == ST_PU_PRM) || (s == ST_PU_CS) || (s == ST_PU_IP);
    endfunction

    function automatic logic st_is_mem(seq_st_e s);
        return st_is_push(s) || (s == ST_RD_SP) || (s == ST_RD_SS) || (s == ST_RD_PRM);
    endfunction

endpackage

// File: rtl/pss_ctrl.sv
module pss_ctrl
    import pss_pkg::*;
#(
    parameter int CNT_W = 5
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic             kind_in,
    input  logic [CNT_W-1:0] cnt_in,
    input  logic             mem_ack,
    output seq_st_e          state,
    output logic             accept,
    output logic             busy,
    output logic             done,
    output logic             mem_req,
    output logic             mem_we,
    output logic [CNT_W-1:0] rem
);
    gate_kind_e kind_q;
    seq_st_e    nxt;

    assign accept  = (state == ST_IDLE) && start;
    assign busy    = (state != ST_IDLE);
    assign done    = (state == ST_FIN);
    assign mem_req = st_is_mem(state);
    assign mem_we  = st_is_push(state);

    always_comb begin
        nxt = state;
        case (state)
            ST_IDLE:   if (start) nxt = ST_RD_SP;
            ST_RD_SP:  if (mem_ack) nxt = ST_RD_SS;
            ST_RD_SS:  if (mem_ack) nxt = ST_PU_SS;
            ST_PU_SS:  if (mem_ack) nxt = ST_PU_SP;
            ST_PU_SP:  if (mem_ack) begin
                           if (kind_q == GATE_INTR) nxt = ST_PU_FL;
                           else if (rem != '0)      nxt = ST_RD_PRM;
                           else                     nxt = ST_PU_CS;
                       end
            ST_PU_FL:  if (mem_ack) nxt = ST_PU_CS;
            ST_RD_PRM: if (mem_ack) nxt = ST_PU_PRM;
            ST_PU_PRM: if (mem_ack) nxt = (rem == CNT_W'(1)) ? ST_PU_CS : ST_RD_PRM;
            ST_PU_CS:  if (mem_ack) nxt = ST_PU_IP;
            ST_PU_IP:  if (mem_ack) nxt = ST_FIN;
            ST_FIN:    nxt = ST_IDLE;
            default:   nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= ST_IDLE;
            kind_q <= GATE_CALL;
            rem    <= '0;
        end else begin
            state <= nxt;
            if (accept) begin
                kind_q <= gate_kind_e'(kind_in);
                rem    <= cnt_in;
            end else if (state == ST_PU_PRM && mem_ack) begin
                rem <= rem - CNT_W'(1);
            end
        end
    end
endmodule

// File: rtl/pss_datapath.sv
module pss_datapath
    import pss_pkg::*;
#(
    parameter int WORD_W = 16,
    parameter int CNT_W  = 5,
    parameter int PL_W   = 2,
    localparam int ADDR_W = 2 * WORD_W
) (
    input  logic              clk,
    input  logic              rst,
    input  seq_st_e           state,
    input  logic              accept,
    input  logic              mem_ack,
    input  logic [WORD_W-1:0] mem_rdata,
    input  logic [CNT_W-1:0]  rem,
    input  logic [PL_W-1:0]   dpl_in,
    input  logic [WORD_W-1:0] gsel_in,
    input  logic [WORD_W-1:0] goff_in,
    input  logic [WORD_W-1:0] oss_in,
    input  logic [WORD_W-1:0] osp_in,
    input  logic [WORD_W-1:0] ocs_in,
    input  logic [WORD_W-1:0] oip_in,
    input  logic [WORD_W-1:0] ofl_in,
    input  logic [ADDR_W-1:0] base_in,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [WORD_W-1:0] mem_wdata,
    output logic [WORD_W-1:0] out_ss,
    output logic [WORD_W-1:0] out_sp,
    output logic [WORD_W-1:0] out_cs,
    output logic [WORD_W-1:0] out_ip,
    output logic [PL_W-1:0]   out_cpl
);
    localparam int WORD_BYTES = WORD_W / 8;
    localparam int SLOT_BYTES = 2 * WORD_BYTES;

    logic [PL_W-1:0]   dpl_q;
    logic [WORD_W-1:0] gsel_q, goff_q, oss_q, osp_q, ocs_q, oip_q, ofl_q;
    logic [ADDR_W-1:0] base_q;
    logic [WORD_W-1:0] nss, nsp, pbuf;
    logic [WORD_W-1:0] push_off, prm_off;
    logic [ADDR_W-1:0] slot_addr;

    assign push_off  = nsp - WORD_W'(WORD_BYTES);
    assign prm_off   = osp_q + WORD_W'(WORD_BYTES) * WORD_W'(rem - CNT_W'(1));
    assign slot_addr = base_q + ADDR_W'(WORD_BYTES) + ADDR_W'(SLOT_BYTES) * ADDR_W'(dpl_q);

    always_comb begin
        case (state)
            ST_RD_SP:  mem_addr = slot_addr;
            ST_RD_SS:  mem_addr = slot_addr + ADDR_W'(WORD_BYTES);
            ST_RD_PRM: mem_addr = {oss_q, prm_off};
            default:   mem_addr = {nss, push_off};
        endcase
    end

    always_comb begin
        case (state)
            ST_PU_SS:  mem_wdata = oss_q;
            ST_PU_SP:  mem_wdata = osp_q;
            ST_PU_FL:  mem_wdata = ofl_q;
            ST_PU_PRM: mem_wdata = pbuf;
            ST_PU_CS:  mem_wdata = ocs_q;
            ST_PU_IP:  mem_wdata = oip_q;
            default:   mem_wdata = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            dpl_q  <= '0;
            gsel_q <= '0;
            goff_q <= '0;
            oss_q  <= '0;
            osp_q  <= '0;
            ocs_q  <= '0;
            oip_q  <= '0;
            ofl_q  <= '0;
            base_q <= '0;
        end else if (accept) begin
            dpl_q  <= dpl_in;
            gsel_q <= gsel_in;
            goff_q <= goff_in;
            oss_q  <= oss_in;
            osp_q  <= osp_in;
            ocs_q  <= ocs_in;
            oip_q  <= oip_in;
            ofl_q  <= ofl_in;
            base_q <= base_in;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            nss  <= '0;
            nsp  <= '0;
            pbuf <= '0;
        end else if (mem_ack) begin
            if (state == ST_RD_SP)  nsp  <= mem_rdata;
            if (state == ST_RD_SS)  nss  <= mem_rdata;
            if (state == ST_RD_PRM) pbuf <= mem_rdata;
            if (st_is_push(state))  nsp  <= push_off;
        end
    end

    assign out_ss  = nss;
    assign out_sp  = nsp;
    assign out_cs  = gsel_q;
    assign out_ip  = goff_q;
    assign out_cpl = dpl_q;
endmodule

// File: rtl/priv_stack_switch.sv
module priv_stack_switch
    import pss_pkg::*;
#(
    parameter int WORD_W = 16,
    parameter int CNT_W  = 5,
    parameter int PL_W   = 2,
    localparam int ADDR_W = 2 * WORD_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic              gate_kind,
    input  logic [PL_W-1:0]   tgt_dpl,
    input  logic [WORD_W-1:0] gate_sel,
    input  logic [WORD_W-1:0] gate_off,
    input  logic [CNT_W-1:0]  gate_wcnt,
    input  logic [WORD_W-1:0] cur_ss,
    input  logic [WORD_W-1:0] cur_sp,
    input  logic [WORD_W-1:0] cur_cs,
    input  logic [WORD_W-1:0] cur_ip,
    input  logic [WORD_W-1:0] cur_flags,
    input  logic [ADDR_W-1:0] tsa_base,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [WORD_W-1:0] mem_wdata,
    input  logic              mem_ack,
    input  logic [WORD_W-1:0] mem_rdata,
    output logic              busy,
    output logic              done,
    output logic [WORD_W-1:0] out_ss,
    output logic [WORD_W-1:0] out_sp,
    output logic [WORD_W-1:0] out_cs,
    output logic [WORD_W-1:0] out_ip,
    output logic [PL_W-1:0]   out_cpl
);
    seq_st_e          state;
    logic             accept;
    logic [CNT_W-1:0] rem;

    pss_ctrl #(.CNT_W(CNT_W)) u_ctrl (
        .clk     (clk),
        .rst     (rst),
        .start   (start),
        .kind_in (gate_kind),
        .cnt_in  (gate_wcnt),
        .mem_ack (mem_ack),
        .state   (state),
        .accept  (accept),
        .busy    (busy),
        .done    (done),
        .mem_req (mem_req),
        .mem_we  (mem_we),
        .rem     (rem)
    );

    pss_datapath #(.WORD_W(WORD_W), .CNT_W(CNT_W), .PL_W(PL_W)) u_dp (
        .clk       (clk),
        .rst       (rst),
        .state     (state),
        .accept    (accept),
        .mem_ack   (mem_ack),
        .mem_rdata (mem_rdata),
        .rem       (rem),
        .dpl_in    (tgt_dpl),
        .gsel_in   (gate_sel),
        .goff_in   (gate_off),
        .oss_in    (cur_ss),
        .osp_in    (cur_sp),
        .ocs_in    (cur_cs),
        .oip_in    (cur_ip),
        .ofl_in    (cur_flags),
        .base_in   (tsa_base),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata),
        .out_ss    (out_ss),
        .out_sp    (out_sp),
        .out_cs    (out_cs),
        .out_ip    (out_ip),
        .out_cpl   (out_cpl)
    );
endmodule

// File: rtl/pss_chk.sv
module pss_chk #(
    parameter int WORD_W = 16,
    localparam int ADDR_W = 2 * WORD_W
) (
    input logic              clk,
    input logic              rst,
    input logic              start,
    input logic              busy,
    input logic              done,
    input logic              mem_req,
    input logic              mem_we,
    input logic              mem_ack,
    input logic [ADDR_W-1:0] mem_addr,
    input logic [WORD_W-1:0] mem_wdata
);
    logic [ADDR_W-1:0] last_wa;
    logic              have_last;

    always_ff @(posedge clk) begin
        if (rst) begin
            last_wa   <= '0;
            have_last <= 1'b0;
        end else if (start && !busy) begin
            have_last <= 1'b0;
        end else if (mem_req && mem_we && mem_ack) begin
            last_wa   <= mem_addr;
            have_last <= 1'b1;
        end
    end

    // R3
    push_descend_chk: assert property (@(posedge clk) disable iff (rst)
        (mem_req && mem_we && mem_ack && have_last) |->
        (mem_addr == {last_wa[ADDR_W-1:WORD_W], last_wa[WORD_W-1:0] - WORD_W'(2)}));

    // R7
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R8
    busy_follow_chk: assert property (@(posedge clk) disable iff (rst)
        (start && !busy) |=> busy);

    // R10
    req_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_ack) |=>
        (mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata)));

    // R10
    idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !busy |-> !mem_req);
endmodule

bind priv_stack_switch pss_chk #(.WORD_W(WORD_W)) u_pss_chk (
    .clk       (clk),
    .rst       (rst),
    .start     (start),
    .busy      (busy),
    .done      (done),
    .mem_req   (mem_req),
    .mem_we    (mem_we),
    .mem_ack   (mem_ack),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata)
);

// File: tb/priv_stack_switch_bench.sv
module priv_stack_switch_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic        gate_kind = 1'b0;
    logic [1:0]  tgt_dpl = '0;
    logic [15:0] gate_sel = '0, gate_off = '0;
    logic [4:0]  gate_wcnt = '0;
    logic [15:0] cur_ss = '0, cur_sp = '0, cur_cs = '0, cur_ip = '0, cur_flags = '0;
    logic [31:0] tsa_base = '0;
    logic        mem_req, mem_we;
    logic [31:0] mem_addr;
    logic [15:0] mem_wdata;
    logic        mem_ack = 1'b0;
    logic [15:0] mem_rdata = '0;
    logic        busy, done;
    logic [15:0] out_ss, out_sp, out_cs, out_ip;
    logic [1:0]  out_cpl;

    int n_chk = 0;
    int n_bad = 0;

    logic [15:0] mem [logic [31:0]];
    bit          exp_we [$];
    logic [31:0] exp_addr [$];
    logic [15:0] exp_data [$];
    string       exp_tag [$];
    logic [7:0]  lfsr = 8'h5A;
    int          wait_cnt = 0;

    always #2.5 clk = ~clk;

    priv_stack_switch u_priv_stack_switch (
        .clk(clk), .rst(rst), .start(start), .gate_kind(gate_kind), .tgt_dpl(tgt_dpl),
        .gate_sel(gate_sel), .gate_off(gate_off), .gate_wcnt(gate_wcnt),
        .cur_ss(cur_ss), .cur_sp(cur_sp), .cur_cs(cur_cs), .cur_ip(cur_ip),
        .cur_flags(cur_flags), .tsa_base(tsa_base),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_ack(mem_ack), .mem_rdata(mem_rdata), .busy(busy), .done(done),
        .out_ss(out_ss), .out_sp(out_sp), .out_cs(out_cs), .out_ip(out_ip), .out_cpl(out_cpl)
    );

    task automatic chk(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    function automatic void expect_op(bit we, logic [31:0] a, logic [15:0] d, string tag);
        exp_we.push_back(we);
        exp_addr.push_back(a);
        exp_data.push_back(d);
        exp_tag.push_back(tag);
    endfunction

    // memory responder: acts at the falling edge, away from the DUT's clock edge
    always @(negedge clk) begin
        if (!rst) begin
            lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
            if (mem_ack) begin
                mem_ack = 1'b0;
            end else if (mem_req) begin
                if (wait_cnt > 0) begin
                    wait_cnt--;
                end else begin
                    if (exp_we.size() == 0) begin
                        chk(1'b0, "R10", "unexpected access", mem_addr, 32'h0);
                    end else begin
                        string tg;
                        bit    ewe;
                        logic [31:0] ea;
                        logic [15:0] ed;
                        ewe = exp_we.pop_front();
                        ea  = exp_addr.pop_front();
                        ed  = exp_data.pop_front();
                        tg  = exp_tag.pop_front();
                        chk(mem_we == ewe, tg, "direction", {31'b0, mem_we}, {31'b0, ewe});
                        chk(mem_addr == ea, tg, "address", mem_addr, ea);
                        if (ewe) chk(mem_wdata == ed, tg, "write data", {16'b0, mem_wdata}, {16'b0, ed});
                    end
                    if (mem_we) mem[mem_addr] = mem_wdata;
                    else        mem_rdata = mem.exists(mem_addr) ? mem[mem_addr] : 16'h0;
                    mem_ack  = 1'b1;
                    wait_cnt = int'(lfsr[1:0]) % 3;
                end
            end
        end
    end

    task automatic run_case(input bit kind, input logic [1:0] dpl, input logic [4:0] cnt,
                            input logic [15:0] oss, input logic [15:0] osp,
                            input logic [15:0] tss_sp, input logic [15:0] tss_ss,
                            input logic [31:0] base, input bit poke);
        logic [15:0] nsp;
        logic [15:0] gs, go, ocs, oip, ofl;
        int          cyc;
        bit          seen;
        gs  = 16'h0100 + 16'(dpl);
        go  = 16'h4000 + 16'(cnt);
        ocs = 16'h00F3 + 16'(cnt);
        oip = 16'h1234 ^ osp;
        ofl = 16'h0202 + 16'(dpl);
        mem[base + 32'(2 + 4 * int'(dpl))] = tss_sp;
        mem[base + 32'(4 + 4 * int'(dpl))] = tss_ss;
        for (int i = 0; i < 32; i++) mem[{oss, osp + 16'(2 * i)}] = 16'hC000 + 16'(i * 7);
        // build reference access list
        expect_op(1'b0, base + 32'(2 + 4 * int'(dpl)), 16'h0, "R2");
        expect_op(1'b0, base + 32'(4 + 4 * int'(dpl)), 16'h0, "R2");
        nsp = tss_sp;
        nsp -= 16'd2; expect_op(1'b1, {tss_ss, nsp}, oss, "R3");
        nsp -= 16'd2; expect_op(1'b1, {tss_ss, nsp}, osp, "R3");
        if (kind) begin
            nsp -= 16'd2; expect_op(1'b1, {tss_ss, nsp}, ofl, "R5");
        end else begin
            for (int i = int'(cnt) - 1; i >= 0; i--) begin
                logic [15:0] so;
                so = osp + 16'(2 * i);
                expect_op(1'b0, {oss, so}, 16'h0, "R4");
                nsp -= 16'd2; expect_op(1'b1, {tss_ss, nsp}, 16'hC000 + 16'(i * 7), "R4");
            end
        end
        nsp -= 16'd2; expect_op(1'b1, {tss_ss, nsp}, ocs, "R6");
        nsp -= 16'd2; expect_op(1'b1, {tss_ss, nsp}, oip, "R6");

        @(negedge clk);
        gate_kind = kind; tgt_dpl = dpl; gate_wcnt = cnt; gate_sel = gs; gate_off = go;
        cur_ss = oss; cur_sp = osp; cur_cs = ocs; cur_ip = oip; cur_flags = ofl;
        tsa_base = base; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(busy == 1'b1, "R8", "busy after start", {31'b0, busy}, 32'h1);
        cyc  = 0;
        seen = 0;
        while (!seen && cyc < 3000) begin
            @(negedge clk);
            cyc++;
            if (poke && cyc == 4) begin
                // R9: a second start mid-sequence with different inputs
                start = 1'b1; cur_ss = ~oss; cur_sp = ~osp; tsa_base = ~base;
                gate_kind = ~kind; tgt_dpl = ~dpl; gate_sel = ~gs; cur_cs = ~ocs;
            end else if (poke && cyc == 5) begin
                start = 1'b0;
            end
            if (done) seen = 1;
            else chk(busy == 1'b1, "R8", "busy during sequence", {31'b0, busy}, 32'h1);
        end
        if (!seen) begin
            chk(1'b0, "R7", "watchdog: no done", 32'h0, 32'h1);
        end else begin
            chk(exp_we.size() == 0, poke ? "R9" : "R6", "accesses left over",
                32'(exp_we.size()), 32'h0);
            chk(out_ss == tss_ss, "R7", "out_ss", {16'b0, out_ss}, {16'b0, tss_ss});
            chk(out_sp == nsp, "R7", "out_sp", {16'b0, out_sp}, {16'b0, nsp});
            chk(out_cs == gs, "R7", "out_cs", {16'b0, out_cs}, {16'b0, gs});
            chk(out_ip == go, "R7", "out_ip", {16'b0, out_ip}, {16'b0, go});
            chk(out_cpl == dpl, "R7", "out_cpl", {30'b0, out_cpl}, {30'b0, dpl});
            @(negedge clk);
            chk(done == 1'b0, "R7", "done one cycle", {31'b0, done}, 32'h0);
            chk(busy == 1'b0, "R8", "busy after done", {31'b0, busy}, 32'h0);
        end
        exp_we.delete(); exp_addr.delete(); exp_data.delete(); exp_tag.delete();
    endtask

    initial begin
        repeat (4) @(negedge clk);
        // R1: reset state
        chk(busy == 1'b0, "R1", "busy in reset", {31'b0, busy}, 32'h0);
        chk(done == 1'b0, "R1", "done in reset", {31'b0, done}, 32'h0);
        chk(mem_req == 1'b0, "R1", "mem_req in reset", {31'b0, mem_req}, 32'h0);
        rst = 1'b0;
        @(negedge clk);
        chk(busy == 1'b0 && mem_req == 1'b0, "R1", "idle after reset",
            {30'b0, busy, mem_req}, 32'h0);
        run_case(1'b0, 2'd0, 5'd0,  16'h002B, 16'h7F00, 16'hFF00, 16'h0010, 32'h0000_8000, 1'b0);
        run_case(1'b0, 2'd1, 5'd3,  16'h003B, 16'h6000, 16'hE000, 16'h0021, 32'h0000_8000, 1'b0);
        run_case(1'b1, 2'd2, 5'd7,  16'h004B, 16'h5554, 16'hD000, 16'h0032, 32'h0001_0040, 1'b0);
        run_case(1'b0, 2'd0, 5'd31, 16'h005B, 16'h4000, 16'hC000, 16'h0010, 32'h0002_0000, 1'b1);
        run_case(1'b1, 2'd0, 5'd0,  16'h006B, 16'h3000, 16'h0002, 16'h0013, 32'h0002_0000, 1'b0);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        #2ms;
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: run did not finish, actual running expected stopped");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule